// File: doc/BRIEF.md
# Word Divider with Condition Flags

This block divides a 32-bit dividend by a 16-bit divisor over many clock cycles. It does one quotient bit per cycle by restoring subtraction. A select input picks signed (two's complement) or unsigned operands. When a division completes without overflow, the block delivers a packed 32-bit word that a register file writes back: the quotient is in the low half and the remainder in the high half. A write-enable pulse travels with that word.

The block also keeps four condition flags: negative (N), zero (Z), overflow (V) and carry (C). An execution pipeline reads them after each operation. A zero divisor does not start the datapath. Instead, a trap-request pulse goes to the exception logic on the next cycle. An operation starts with a one-cycle `start` pulse while `busy` is low. It ends with a one-cycle `done` pulse.

Top module: `wdiv_unit`

## Requirements
- R1: A `start` seen while `busy` is low and with a nonzero divisor raises `busy` on the next cycle. `done` pulses for one cycle 33 clock edges after the start edge in unsigned mode and 34 in signed mode, and `busy` is low during that `done` cycle.
- R2: A `start` with divisor 0 raises `done` and `div0_trap` for one cycle on the next edge. `wr_en` stays low, `busy` never rises, and N, Z, V and `result` keep their values.
- R3: `flag_c` reads 0 after reset and after every operation, including a zero-divisor trap and an overflow.
- R4: In a completion without overflow, `wr_en` pulses together with `done`, `result[15:0]` holds the quotient and `result[31:16]` holds the remainder.
- R5: In unsigned mode (`signed_mode`=0) an operation overflows exactly when the quotient is greater than 65535.
- R6: In signed mode (`signed_mode`=1) an operation overflows exactly when the quotient lies outside -32768..32767.
- R7: On overflow `wr_en` stays low, V becomes 1, Z becomes 0, N keeps its earlier value, and `result` does not change.
- R8: Without overflow, V becomes 0, Z becomes 1 exactly when the 16-bit quotient is zero, and N equals quotient bit 15.
- R9: Signed division truncates toward zero, and the remainder carries the sign of the dividend (or is zero).
- R10: A `start` pulse that arrives while `busy` is high is ignored, and the operation in progress completes with its own operands.
- R11: After reset, `busy`, `done`, `wr_en`, `div0_trap`, `result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while idle) |
| dividend | input | 32 | Dividend operand |
| divisor | input | 16 | Divisor operand |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Remainder in 31:16, quotient in 15:0 |
| wr_en | output | 1 | Destination write strobe, pulses with `done` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always cleared |
| div0_trap | output | 1 | Divide-by-zero trap request pulse |

## Verification
The hardest cases to reach are the signed overflow edges: quotients of exactly -32768 and +32768, and the most negative dividend divided by -1. In these cases the unsigned magnitude and the corrected sign disagree about whether the value fits. The stimulus picks dividends that land exactly on these boundaries. It also runs an overflow right after an operation that left N set, so the bench can see that N is held. A second `start` is sent in the middle of a running operation to show that it is ignored.

// File: rtl/wdiv_pkg.sv
// Shared types for the word divider.
package wdiv_pkg;
    // Sequencer phases of one division.
    typedef enum logic [1:0] {
        DV_IDLE  = 2'd0,
        DV_RUN   = 2'd1,
        DV_FIX   = 2'd2,
        DV_CLOSE = 2'd3
    } dv_state_e;
endpackage

// File: rtl/wdiv_sign_prep.sv
// Operand conditioning: converts the operands to unsigned magnitudes and
// works out the sign the quotient and remainder need after the divide.
// Assumes two's complement operands when sgn is set; the most negative
// dividend maps to its own bit pattern, which is the correct magnitude.
module wdiv_sign_prep #(
    parameter int DVS_W = 16
) (
    input  logic [2*DVS_W-1:0] dvd,
    input  logic [DVS_W-1:0]   dvs,
    input  logic               sgn,
    output logic [2*DVS_W-1:0] dvd_mag,
    output logic [DVS_W-1:0]   dvs_mag,
    output logic               neg_q,
    output logic               neg_r
);
    localparam int DVD_W = 2 * DVS_W;

    logic dvd_neg;
    logic dvs_neg;

    // Magnitudes and result signs.
    always_comb begin
        dvd_neg = sgn & dvd[DVD_W-1];
        dvs_neg = sgn & dvs[DVS_W-1];
        dvd_mag = dvd_neg ? (~dvd + 1'b1) : dvd;
        dvs_mag = dvs_neg ? (~dvs + 1'b1) : dvs;
        neg_q   = dvd_neg ^ dvs_neg;
        neg_r   = dvd_neg;
    end
endmodule

// File: rtl/wdiv_shift_core.sv
// Restoring shift-subtract datapath. load captures the magnitudes, and each
// step produces one quotient bit, MSB first. fix applies the stored sign
// corrections to quotient and remainder. Assumes a nonzero divisor and that
// the controls are one-hot.
module wdiv_shift_core #(
    parameter int DVS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               fix,
    input  logic [2*DVS_W-1:0] dvd_mag,
    input  logic [DVS_W-1:0]   dvs_mag,
    input  logic               neg_q,
    input  logic               neg_r,
    output logic [2*DVS_W-1:0] quo,
    output logic [DVS_W-1:0]   rem
);
    localparam int DVD_W = 2 * DVS_W;

    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_q;
    logic             neg_q_q;
    logic             neg_r_q;
    logic [DVS_W:0]   partial;
    logic [DVS_W+1:0] diff;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        partial = {rem_q, quo_q[DVD_W-1]};
        diff    = {1'b0, partial} - {2'b00, dvs_q};
        fits    = ~diff[DVS_W+1];
    end

    // Operand capture, iteration and sign correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
        end else if (load) begin
            quo_q   <= dvd_mag;
            rem_q   <= '0;
            dvs_q   <= dvs_mag;
            neg_q_q <= neg_q;
            neg_r_q <= neg_r;
        end else if (step) begin
            quo_q <= {quo_q[DVD_W-2:0], fits};
            rem_q <= fits ? diff[DVS_W-1:0] : partial[DVS_W-1:0];
        end else if (fix) begin
            if (neg_q_q) quo_q <= ~quo_q + 1'b1;
            if (neg_r_q) rem_q <= ~rem_q + 1'b1;
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;

    // R4: each restoring step leaves a partial remainder below the divisor
    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q < dvs_q));
endmodule

// File: rtl/wdiv_judge.sv
// Overflow detection on the sign-corrected full-width quotient. Unsigned:
// any bit above the low half is set. Signed: the upper half plus the
// low-half sign bit do not all agree.
module wdiv_judge #(
    parameter int DVS_W = 16
) (
    input  logic [2*DVS_W-1:0] quo,
    input  logic               sgn,
    output logic               ovf
);
    localparam int DVD_W = 2 * DVS_W;

    logic [DVD_W-DVS_W:0] top_bits;

    // Range test selected by mode.
    always_comb begin
        top_bits = quo[DVD_W-1:DVS_W-1];
        if (sgn) ovf = ~((&top_bits) | ~(|top_bits));
        else     ovf = |quo[DVD_W-1:DVS_W];
    end
endmodule

// File: rtl/wdiv_flag_reg.sv
// Condition flag state. A zero-divisor trap clears only carry. A completed
// operation clears carry and then either reports overflow (N kept) or
// reports the quotient's sign and zero state.
module wdiv_flag_reg #(
    parameter int DVS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_zero,
    input  logic             upd_fin,
    input  logic             ovf,
    input  logic [DVS_W-1:0] q_low,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c
);
    // Flag update per outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
        end else if (upd_zero) begin
            flag_c <= 1'b0;
        end else if (upd_fin) begin
            flag_c <= 1'b0;
            if (ovf) begin
                flag_v <= 1'b1;
                flag_z <= 1'b0;
            end else begin
                flag_v <= 1'b0;
                flag_z <= ~(|q_low);
                flag_n <= q_low[DVS_W-1];
            end
        end
    end

    // R7
    ovf_keep_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fin && ovf) |=> (flag_v && !flag_z && flag_n == $past(flag_n)));
    // R2
    trap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_zero |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_v)));
endmodule

// File: rtl/wdiv_unit.sv
// Word divider top: sequences a 32/16 restoring divide (one quotient bit per
// cycle, plus a sign-fixup cycle in signed mode), judges overflow, updates
// flags and issues the write strobe or the divide-by-zero trap. Assumes
// start is a pulse and that operands are valid in the start cycle only.
module wdiv_unit #(
    parameter int DVS_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2*DVS_W-1:0]    dividend,
    input  logic [DVS_W-1:0]      divisor,
    input  logic                  signed_mode,
    output logic                  busy,
    output logic                  done,
    output logic [2*DVS_W-1:0]    result,
    output logic                  wr_en,
    output logic                  flag_n,
    output logic                  flag_z,
    output logic                  flag_v,
    output logic                  flag_c,
    output logic                  div0_trap
);
    import wdiv_pkg::*;

    localparam int DVD_W = 2 * DVS_W;
    localparam int CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DVD_W - 1);

    dv_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic              sgn_q;
    logic              launch;
    logic              zero_req;
    logic              closing;
    logic [DVD_W-1:0]  dvd_mag;
    logic [DVS_W-1:0]  dvs_mag;
    logic              neg_q;
    logic              neg_r;
    logic [DVD_W-1:0]  quo;
    logic [DVS_W-1:0]  rem;
    logic              ovf;
    logic              done_q;
    logic              wr_q;
    logic              trap_q;
    logic [DVD_W-1:0]  result_q;

    // Request decode in the idle phase.
    always_comb begin
        launch   = (state == DV_IDLE) && start && (divisor != '0);
        zero_req = (state == DV_IDLE) && start && (divisor == '0);
        closing  = (state == DV_CLOSE);
    end

    wdiv_sign_prep #(.DVS_W(DVS_W)) u_prep (
        .dvd     (dividend),
        .dvs     (divisor),
        .sgn     (signed_mode),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .neg_q   (neg_q),
        .neg_r   (neg_r)
    );

    wdiv_shift_core #(.DVS_W(DVS_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .step    (state == DV_RUN),
        .fix     (state == DV_FIX),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .neg_q   (neg_q),
        .neg_r   (neg_r),
        .quo     (quo),
        .rem     (rem)
    );

    wdiv_judge #(.DVS_W(DVS_W)) u_judge (
        .quo (quo),
        .sgn (sgn_q),
        .ovf (ovf)
    );

    wdiv_flag_reg #(.DVS_W(DVS_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_zero (zero_req),
        .upd_fin  (closing),
        .ovf      (ovf),
        .q_low    (quo[DVS_W-1:0]),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .flag_v   (flag_v),
        .flag_c   (flag_c)
    );

    // Phase sequencer with bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DV_IDLE;
            cnt   <= '0;
            sgn_q <= 1'b0;
        end else begin
            case (state)
                DV_IDLE: begin
                    if (launch) begin
                        state <= DV_RUN;
                        cnt   <= '0;
                        sgn_q <= signed_mode;
                    end
                end
                DV_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_STEP) state <= sgn_q ? DV_FIX : DV_CLOSE;
                end
                DV_FIX:   state <= DV_CLOSE;
                DV_CLOSE: state <= DV_IDLE;
                default:  state <= DV_IDLE;
            endcase
        end
    end

    // Completion pulses and destination word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            wr_q     <= 1'b0;
            trap_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= zero_req | closing;
            wr_q   <= closing & ~ovf;
            trap_q <= zero_req;
            if (closing && !ovf) result_q <= {rem, quo[DVS_W-1:0]};
        end
    end

    assign busy      = (state != DV_IDLE);
    assign done      = done_q;
    assign wr_en     = wr_q;
    assign div0_trap = trap_q;
    assign result    = result_q;

    // R1
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && divisor != '0) |=> busy);
    // R2
    div0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div0_trap |-> (done && !wr_en && !busy));
    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_c);
    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_en) |-> $stable(result));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!flag_v && flag_z == (result[DVS_W-1:0] == '0)
                   && flag_n == result[DVS_W-1]));
endmodule

// File: tb/wdiv_unit_test.sv
`timescale 1ns/1ps
module wdiv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        signed_mode = 1'b0;
    logic        busy, done, wr_en, flag_n, flag_z, flag_v, flag_c, div0_trap;
    logic [31:0] result;

    wdiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .signed_mode(signed_mode), .busy(busy),
        .done(done), .result(result), .wr_en(wr_en), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .div0_trap(div0_trap)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_tag = "R11";

    // Behavioural reference model state.
    int          m_cnt = 0;
    logic        m_done = 0, m_wr = 0, m_trap = 0;
    logic        m_n = 0, m_z = 0, m_v = 0, m_c = 0;
    logic [31:0] m_res = 0;
    logic        p_ovf = 0;
    logic [31:0] p_res = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_wr = 0; m_trap = 0;
            m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_res = 0;
        end else begin
            m_done = 0; m_wr = 0; m_trap = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_c = 0;
                    if (p_ovf) begin
                        m_v = 1; m_z = 0;
                    end else begin
                        m_wr = 1; m_v = 0; m_res = p_res;
                        m_z = (p_res[15:0] == 0); m_n = p_res[15];
                    end
                end
            end else if (start) begin
                if (divisor == 0) begin
                    m_done = 1; m_trap = 1; m_c = 0;
                end else begin
                    longint a, b, q, r;
                    if (signed_mode) begin
                        a = longint'($signed(dividend));
                        b = longint'($signed(divisor));
                    end else begin
                        a = longint'(dividend);
                        b = longint'(divisor);
                    end
                    q = a / b;
                    r = a % b;
                    p_ovf = signed_mode ? (q < -32768 || q > 32767) : (q > 65535);
                    p_res = {r[15:0], q[15:0]};
                    m_cnt = signed_mode ? 34 : 33;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (during %s) act=%h exp=%h at cycle %0d", tag, cur_tag, act, exp, cycles);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R1 busy", 32'(busy), 32'(m_cnt > 0));
            chk("R1 done", 32'(done), 32'(m_done));
            chk("R2 div0_trap", 32'(div0_trap), 32'(m_trap));
            chk("R3 flag_c", 32'(flag_c), 32'(m_c));
            chk("R4 result", result, m_res);
            chk("R7 wr_en", 32'(wr_en), 32'(m_wr));
            chk("R7 flag_v", 32'(flag_v), 32'(m_v));
            chk("R8 flag_z", 32'(flag_z), 32'(m_z));
            chk("R8 flag_n", 32'(flag_n), 32'(m_n));
        end
    end

    task automatic op(input string tag, input logic [31:0] a, input logic [15:0] b, input logic s);
        cur_tag = tag;
        @(negedge clk);
        dividend = a; divisor = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0; dividend = '0; divisor = '0;
        repeat (38) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset outputs", {busy, done, wr_en, div0_trap, flag_n, flag_z, flag_v, flag_c},
            32'd0);
        chk("R11 reset result", result, 32'd0);
        op("R4", 32'd100000, 16'd7, 1'b0);
        op("R8", 32'd5, 16'd9, 1'b0);
        op("R5", 32'h0001_FFFF, 16'd2, 1'b0);
        op("R5", 32'h0002_0000, 16'd2, 1'b0);
        op("R5", 32'h1234_5678, 16'd3, 1'b0);
        op("R2", 32'h0000_1234, 16'd0, 1'b0);
        op("R9", -32'sd100, 16'd7, 1'b1);
        op("R9", 32'd100, -16'sd7, 1'b1);
        op("R9", -32'sd100, -16'sd7, 1'b1);
        op("R6", -32'sd65536, 16'd2, 1'b1);
        op("R6", 32'd65536, 16'd2, 1'b1);
        op("R7", 32'h8000_0000, 16'hFFFF, 1'b1);
        op("R6", 32'h4000_0000, 16'd2, 1'b1);
        op("R2", -32'sd5, 16'd0, 1'b1);
        op("R8", 32'd65535, 16'd1, 1'b0);
        // R10: start during busy must be ignored
        cur_tag = "R10";
        @(negedge clk);
        dividend = 32'd1000; divisor = 16'd10; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dividend = 32'd7; divisor = 16'd0; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (35) @(negedge clk);
        chk("R10 result of first operands", result, {16'd0, 16'd100});
        finish_run();
    end

    initial begin
        wait (cycles > 5000);
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp<5000", cycles);
        finish_run();
    end
endmodule